// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Scaled Readout

This block is the multiply-accumulate engine of a 32-bit processor core. It keeps a 64-bit signed accumulator as a high word and a low word. On each accepted operation it either adds or subtracts the full signed 64-bit product of two 32-bit operands, or it reads out a scaled window of the accumulator and clears the accumulator. Every operation takes one clock, so the next operation sees the updated accumulator at once.

Operations arrive on a valid/ready stream. The readout leaves on a valid/ready stream as well. The readout register holds one result. While a result is presented and not yet taken (`rd_valid` high, `rd_ready` low), the block lowers `op_ready`, and no operation of any kind is accepted until the consumer takes the result. With `rd_ready` held high the readout is a single-cycle pulse one clock after the read-and-clear is accepted.

Software can load either half of the accumulator directly through a plain write port and can watch both halves at all times. An accepted arithmetic operation wins over a direct write in the same cycle.

Top module: `mac_acc_unit`

## Requirements
- R1: After reset both accumulator halves read zero and `rd_valid` is low.
- R2: An accepted operation with `op_code` 2'b00 adds the sign-extended 64-bit product `op_a*op_b` to the accumulator. The new value is visible on `acc_hi`/`acc_lo` after the accepting edge. Overflow wraps modulo 2^64 with no flag.
- R3: An accepted operation with `op_code` 2'b01 subtracts the same signed 64-bit product from the accumulator, also wrapping modulo 2^64.
- R4: An accepted operation with `op_code` 2'b10 captures accumulator bits [59:28] into `rd_data`. This is the accumulator shifted arithmetically right by 28, truncated to 32 bits. The same edge sets both halves to zero.
- R5: `rd_valid` rises on the edge that accepts a read-and-clear. With `rd_ready` high it stays high for exactly one cycle. A read-and-clear accepted the cycle after a multiply-add returns the updated sum.
- R6: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high, `rd_data` is stable and `op_ready` is low.
- R7: `wr_hi_en` loads `wr_data` into `acc_hi` and `wr_lo_en` loads it into `acc_lo`, each on its own, visible after the next edge.
- R8: When an operation with `op_code` 2'b00, 2'b01 or 2'b10 is accepted in the same cycle as a direct write, the operation's result is stored and the write is dropped.
- R9: An accepted operation with `op_code` 2'b11 leaves the accumulator unchanged and produces no readout. Direct writes in the same cycle still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation can be accepted this cycle |
| op_code | input | 2 | 00 add product, 01 subtract product, 10 read and clear, 11 no operation |
| op_a | input | 32 | Signed multiplicand |
| op_b | input | 32 | Signed multiplier |
| wr_hi_en | input | 1 | Load `wr_data` into the high half |
| wr_lo_en | input | 1 | Load `wr_data` into the low half |
| wr_data | input | 32 | Direct write data |
| acc_hi | output | 32 | Accumulator bits [63:32] |
| acc_lo | output | 32 | Accumulator bits [31:0] |
| rd_valid | output | 1 | Readout available |
| rd_ready | input | 1 | Consumer takes the readout |
| rd_data | output | 32 | Accumulator bits [59:28] captured at read-and-clear |

## Verification
Both accumulator halves are outputs, so a wrong sum, a wrong sign extension or a missed clear shows up on `acc_hi`/`acc_lo` one clock after the faulty operation. The bench compares them after every operation. A bad readout window or a clear applied before the capture appears on `rd_data` one clock after the read-and-clear. A lost back-pressure hold shows as `rd_valid` falling, or `op_ready` rising, while `rd_ready` is still low, and the bench catches this within the same cycle. Corner operands include the most negative value squared, minus one against both extremes, and enough large products to wrap bit 63.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_MADD  = 2'b00,
    OP_MSUB  = 2'b01,
    OP_RDCLR = 2'b10,
    OP_NONE  = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_product.sv
// Full-width signed product of two DW-bit operands.
module mac_product #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [2*DW-1:0] prod
);
  logic signed [2*DW-1:0] a_ext, b_ext, full;

  always_comb begin
    a_ext = {{DW{a[DW-1]}}, a};
    b_ext = {{DW{b[DW-1]}}, b};
    full  = a_ext * b_ext;
    prod  = full;
  end
endmodule

// File: rtl/mac_accum.sv
// Two-half accumulator. An arithmetic operation wins over a direct write.
module mac_accum
  import mac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arith,
  input  mac_op_e         op,
  input  logic [2*DW-1:0] prod,
  input  logic            wr_hi_en,
  input  logic            wr_lo_en,
  input  logic [DW-1:0]   wr_data,
  output logic [2*DW-1:0] acc
);
  localparam int AW    = 2 * DW;
  localparam int HALVES = 2;

  logic [AW-1:0] nxt;

  always_comb begin
    unique case (op)
      OP_MADD: nxt = acc + prod;
      OP_MSUB: nxt = acc - prod;
      default: nxt = '0;
    endcase
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [DW-1:0] half_q;
    logic          wen;
    assign wen = (h == 0) ? wr_lo_en : wr_hi_en;

    always_ff @(posedge clk) begin
      if (!rst_n)      half_q <= '0;
      else if (arith)  half_q <= nxt[h*DW +: DW];
      else if (wen)    half_q <= wr_data;
    end

    assign acc[h*DW +: DW] = half_q;
  end
endmodule

// File: rtl/mac_readout.sv
// One-entry readout register with valid/ready hold.
module mac_readout #(
  parameter int DW    = 32,
  parameter int SHIFT = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [2*DW-1:0] acc,
  input  logic            rd_ready,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data
);
  // For SHIFT <= DW the low DW bits of an arithmetic right shift
  // are exactly the window acc[SHIFT +: DW].
  logic [DW-1:0] window;
  assign window = acc[SHIFT +: DW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (capture) begin
      rd_valid <= 1'b1;
      rd_data  <= window;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
  import mac_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SHIFT = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [1:0]    op_code,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          wr_hi_en,
  input  logic          wr_lo_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] acc_hi,
  output logic [DW-1:0] acc_lo,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data
);
  localparam int AW = 2 * DW;

  mac_op_e       op;
  logic          fire, arith, capture;
  logic [AW-1:0] prod, acc;

  assign op       = mac_op_e'(op_code);
  assign op_ready = !(rd_valid && !rd_ready);
  assign fire     = op_valid && op_ready;
  assign arith    = fire && (op != OP_NONE);
  assign capture  = fire && (op == OP_RDCLR);

  mac_product #(.DW(DW)) u_prod (
    .a(op_a), .b(op_b), .prod(prod)
  );

  mac_accum #(.DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .arith(arith), .op(op), .prod(prod),
    .wr_hi_en(wr_hi_en), .wr_lo_en(wr_lo_en), .wr_data(wr_data), .acc(acc)
  );

  mac_readout #(.DW(DW), .SHIFT(SHIFT)) u_rd (
    .clk(clk), .rst_n(rst_n), .capture(capture), .acc(acc),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign acc_hi = acc[AW-1:DW];
  assign acc_lo = acc[DW-1:0];
endmodule

// File: rtl/mac_acc_unit_chk.sv
module mac_acc_unit_chk
  import mac_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SHIFT = 28
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          op_ready,
  input logic [1:0]    op_code,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic          wr_hi_en,
  input logic          wr_lo_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] acc_hi,
  input logic [DW-1:0] acc_lo,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data
);
  logic            fire, busy;
  logic [2*DW-1:0] acc, prd;

  assign fire = op_valid && op_ready;
  assign busy = fire && (op_code != OP_NONE);
  assign acc  = {acc_hi, acc_lo};
  assign prd  = {{DW{op_a[DW-1]}}, op_a} * {{DW{op_b[DW-1]}}, op_b};

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (acc == '0) && !rd_valid);                                   // R1
  AST_MADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_code == OP_MADD |=> acc == $past(acc) + $past(prd));          // R2
  AST_MSUB_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_code == OP_MSUB |=> acc == $past(acc) - $past(prd));          // R3
  AST_RDCLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_code == OP_RDCLR |=> acc == '0);                              // R4
  AST_RDCLR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_code == OP_RDCLR |=> rd_valid && rd_data == $past(acc[SHIFT +: DW])); // R5
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !(fire && op_code == OP_RDCLR) |=> !rd_valid);  // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));                 // R6
  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |-> !op_ready);                                    // R6
  AST_WR_HI: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && wr_hi_en |=> acc_hi == $past(wr_data));                         // R7
  AST_WR_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && wr_lo_en |=> acc_lo == $past(wr_data));                         // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !wr_hi_en && !wr_lo_en |=> $stable(acc));                       // R8
  AST_NOP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_code == OP_NONE && !rd_valid |=> !rd_valid);                  // R9
endmodule

bind mac_acc_unit mac_acc_unit_chk #(.DW(DW), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_code(op_code), .op_a(op_a), .op_b(op_b), .wr_hi_en(wr_hi_en),
  .wr_lo_en(wr_lo_en), .wr_data(wr_data), .acc_hi(acc_hi), .acc_lo(acc_lo),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/mac_acc_unit_tb.sv
`timescale 1ns/1ps
module mac_acc_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic        op_valid = 0, op_ready;
  logic [1:0]  op_code = 0;
  logic [31:0] op_a = 0, op_b = 0;
  logic        wr_hi_en = 0, wr_lo_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] acc_hi, acc_lo, rd_data;
  logic        rd_valid, rd_ready = 1;

  int checks = 0, fails = 0;
  bit done = 0;
  longint ref_acc = 0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  mac_acc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_a(op_a), .op_b(op_b), .wr_hi_en(wr_hi_en),
    .wr_lo_en(wr_lo_en), .wr_data(wr_data), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint sprod(input logic [31:0] a, input logic [31:0] b);
    longint x, y;
    x = longint'(signed'(a));
    y = longint'(signed'(b));
    return x * y;
  endfunction

  // Driver: phase is one time unit after a rising edge.
  task automatic do_op(input logic [1:0] code, input logic [31:0] a, input logic [31:0] b,
                       input logic whi = 0, input logic wlo = 0, input logic [31:0] wd = 0);
    logic [63:0] t;
    op_valid = 1; op_code = code; op_a = a; op_b = b;
    wr_hi_en = whi; wr_lo_en = wlo; wr_data = wd;
    forever begin @(negedge clk); if (op_ready) break; end
    case (code)
      2'b00: ref_acc = ref_acc + sprod(a, b);
      2'b01: ref_acc = ref_acc - sprod(a, b);
      2'b10: begin t = ref_acc; exp_q.push_back(t[59:28]); ref_acc = 0; end
      default: begin
        t = ref_acc;
        if (whi) t[63:32] = wd;
        if (wlo) t[31:0]  = wd;
        ref_acc = t;
      end
    endcase
    @(posedge clk); #1;
    op_valid = 0; wr_hi_en = 0; wr_lo_en = 0;
  endtask

  task automatic do_wr(input logic whi, input logic wlo, input logic [31:0] wd);
    logic [63:0] t;
    wr_hi_en = whi; wr_lo_en = wlo; wr_data = wd;
    @(posedge clk); #1;
    wr_hi_en = 0; wr_lo_en = 0;
    t = ref_acc;
    if (whi) t[63:32] = wd;
    if (wlo) t[31:0]  = wd;
    ref_acc = t;
  endtask

  task automatic chk_acc(input string req);
    chk({acc_hi, acc_lo} == ref_acc, req, {acc_hi, acc_lo}, ref_acc);
  endtask

  // Monitor: pops an expected readout for each completed handshake.
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected readout", {32'h0, rd_data}, 64'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R4 readout window", {32'h0, rd_data}, {32'h0, e});
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({acc_hi, acc_lo} == 0, "R1 reset acc", {acc_hi, acc_lo}, 0);
    chk(rd_valid == 0, "R1 reset rd_valid", {63'h0, rd_valid}, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R2 corner: most negative squared, then minus one products
    do_op(2'b00, 32'h8000_0000, 32'h8000_0000); chk_acc("R2 min*min");
    do_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF); chk_acc("R2 -1*-1");
    do_op(2'b00, 32'hFFFF_FFFF, 32'h8000_0000); chk_acc("R2 -1*min");
    do_op(2'b00, 32'hFFFF_FFFF, 32'h7FFF_FFFF); chk_acc("R2 -1*max");
    // R2 wrap past bit 63
    for (int i = 0; i < 4; i++) begin
      do_op(2'b00, 32'h8000_0000, 32'h8000_0000); chk_acc("R2 wrap");
    end
    // R3 subtract to negative
    do_op(2'b01, 32'h7FFF_FFFF, 32'h7FFF_FFFF); chk_acc("R3 sub max*max");
    do_op(2'b01, 32'h8000_0000, 32'hFFFF_FFFF); chk_acc("R3 sub min*-1");

    // R4/R5 read-clear of a negative accumulator, back to back after add
    do_op(2'b00, 32'h1234_5678, 32'hFEDC_BA98); chk_acc("R2 pre-read add");
    do_op(2'b10, 32'h0, 32'h0);
    chk(rd_valid == 1, "R5 rd_valid after read-clear", {63'h0, rd_valid}, 1);
    chk_acc("R4 acc cleared");
    @(posedge clk); #1;
    chk(rd_valid == 0, "R5 single-cycle pulse", {63'h0, rd_valid}, 0);

    // R6 back-pressure
    do_op(2'b00, 32'h0010_0000, 32'h0000_3000);
    rd_ready = 0;
    do_op(2'b10, 32'h0, 32'h0);
    begin
      logic [31:0] held;
      held = rd_data;
      for (int i = 0; i < 3; i++) begin
        chk(op_ready == 0, "R6 op_ready low while held", {63'h0, op_ready}, 0);
        chk(rd_valid == 1 && rd_data == held, "R6 hold", {32'h0, rd_data}, {32'h0, held});
        @(posedge clk); #1;
      end
    end
    rd_ready = 1;
    @(posedge clk); #1;
    chk(rd_valid == 0 && op_ready == 1, "R6 release", {62'h0, rd_valid, op_ready}, 64'h1);

    // R7 direct writes
    do_wr(1, 0, 32'hDEAD_BEEF); chk_acc("R7 write hi");
    do_wr(0, 1, 32'hCAFE_F00D); chk_acc("R7 write lo");
    do_wr(1, 1, 32'h0F0F_0F0F); chk_acc("R7 write both");

    // R8 arithmetic beats write
    do_op(2'b00, 32'h0000_0003, 32'h0000_0005, 1, 1, 32'h5555_5555); chk_acc("R8 add over write");
    do_op(2'b01, 32'hFFFF_FFF0, 32'h0000_0007, 1, 0, 32'hAAAA_AAAA); chk_acc("R8 sub over write");

    // R9 no-op code
    do_op(2'b11, 32'h7FFF_FFFF, 32'h7FFF_FFFF); chk_acc("R9 nop keeps acc");
    chk(rd_valid == 0, "R9 nop no readout", {63'h0, rd_valid}, 0);
    do_op(2'b11, 32'h1, 32'h1, 0, 1, 32'h0000_1234); chk_acc("R9 nop lets write through");

    // Random mixed traffic (R2 R3 R4)
    for (int i = 0; i < 400; i++) begin
      logic [1:0] c;
      c = 2'($urandom_range(0, 9) == 0 ? 2 : $urandom_range(0, 1));
      do_op(c, $urandom, $urandom);
      chk_acc("R2/R3/R4 random");
    end
    do_op(2'b10, 32'h0, 32'h0);
    repeat (3) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "R5 all readouts seen", exp_q.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule